// File: doc/BRIEF.md
# Shadowed Output Polarity Controller

This block sets the level of seven compare/PWM output lines. Each line has a passive level held in an 8-bit level register. While a line's channel is passive, the line drives that level. While the channel is active, the line drives the inverted level. Software reaches the register through a small synchronous port with a write enable, 8-bit write data and 8-bit read data.

Six of the level bits are double-buffered. A write lands in a shadow copy, and reads return the working copy that drives the lines. The shadow moves into the working copy only when an external timer shadow-transfer strobe is high. Because of this, the polarity of those six lines never changes partway through a PWM period.

The seventh line's level bit has no shadow copy and takes effect on the clock edge of the write. One register bit is reserved. The per-line active/passive states and the transfer strobe come from outside the block.

Top module: `passive_level_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the read data is 0x00 and every line output is 0. Both the shadow and the working copies reset to 0.
- R2: Each output line is registered. One clock edge after a cycle, line i equals that cycle's passive level for line i, XORed with active_i[i] (1 = active, 0 = passive).
- R3: A write to register bits [5:0] without a transfer strobe changes neither the read data nor the line outputs.
- R4: On a clock edge with the transfer strobe high, working bits [5:0] take the shadow bits. The new values appear on read data right after that edge, and on the lines one edge later.
- R5: Register bit 7 is unbuffered. A write updates it on that clock edge, so read data bit 7 shows it right after the edge, and line 6 follows one edge later.
- R6: Register bit 6 always reads as 0, and writing 1 to it has no effect on read data or lines.
- R7: When a write and a transfer strobe fall on the same edge, working bits [5:0] take the old shadow value and the shadow takes the new write data.
- R8: Register bits 0..5 set the passive levels of lines 0..5 in that order, and register bit 7 sets the passive level of line 6. A bit value of 1 means a high passive level and 0 means a low one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write enable |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data (working copy, bit 6 zero) |
| xfer_i | input | 1 | Timer shadow-transfer strobe |
| active_i | input | 7 | Per-line channel state, 1 = active |
| line_o | output | 7 | Registered output lines |

## Verification
Read data reflects the register state one edge after a write or a transfer strobe. Line outputs trail the register state and the active inputs by one further register stage. The scoreboard drives inputs on the falling edge. For each cycle it queues the read value expected after the next rising edge, and the line value computed from the state and active inputs that existed before that edge. The monitor samples shortly after each rising edge and compares against the queued item. This keeps every comparison aligned to the single cycle in which the result is due.

// File: rtl/plc_pkg.sv
package plc_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_SHAD  = 6;
  localparam int OUT_W     = NUM_SHAD + 1;
  localparam int RSV_BIT   = 6;
  localparam int DIRECT_BIT = 7;

  typedef logic [REG_W-1:0]    reg_t;
  typedef logic [NUM_SHAD-1:0] shad_t;
  typedef logic [OUT_W-1:0]    line_t;

  // Assemble the software view of the register.
  function automatic reg_t pack_read(input shad_t work, input logic direct);
    reg_t r;
    r = '0;
    r[NUM_SHAD-1:0] = work;
    r[DIRECT_BIT]   = direct;
    r[RSV_BIT]      = 1'b0;
    return r;
  endfunction

  // Place per-register-bit levels on their output lines.
  function automatic line_t map_levels(input shad_t work, input logic direct);
    line_t l;
    for (int i = 0; i < NUM_SHAD; i++) l[i] = work[i];
    l[OUT_W-1] = direct;
    return l;
  endfunction

  // Active state drives the inverse of the passive level.
  function automatic logic drive_level(input logic passive, input logic active);
    return passive ^ active;
  endfunction
endpackage

// File: rtl/plc_shadow_bank.sv
module plc_shadow_bank
  import plc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en_i,
  input  shad_t wr_bits_i,
  output shad_t shadow_o
);
  genvar g;
  generate
    for (g = 0; g < NUM_SHAD; g++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= 1'b0;
        else if (wr_en_i) q <= wr_bits_i[g];
      end
      assign shadow_o[g] = q;
    end
  endgenerate
endmodule

// File: rtl/plc_work_bank.sv
module plc_work_bank
  import plc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  xfer_i,
  input  shad_t shadow_i,
  input  logic  wr_en_i,
  input  logic  direct_bit_i,
  output shad_t work_o,
  output logic  direct_o
);
  shad_t work_q;
  logic  direct_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      work_q <= '0;
    else if (xfer_i) work_q <= shadow_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       direct_q <= 1'b0;
    else if (wr_en_i) direct_q <= direct_bit_i;
  end

  assign work_o   = work_q;
  assign direct_o = direct_q;
endmodule

// File: rtl/plc_line_driver.sv
module plc_line_driver
  import plc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  line_t passive_i,
  input  line_t active_i,
  output line_t line_o
);
  genvar g;
  generate
    for (g = 0; g < OUT_W; g++) begin : g_line
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= drive_level(passive_i[g], active_i[g]);
      end
      assign line_o[g] = q;
    end
  endgenerate
endmodule

// File: rtl/passive_level_ctrl.sv
module passive_level_ctrl
  import plc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic       xfer_i,
  input  logic [6:0] active_i,
  output logic [6:0] line_o
);
  // Named internal events for the checker.
  shad_t shadow_q;
  shad_t work_q;
  logic  direct_q;
  line_t passive_lvl;
  logic  unused_rsvd;

  assign unused_rsvd = wr_data_i[RSV_BIT];

  plc_shadow_bank u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .wr_bits_i(wr_data_i[NUM_SHAD-1:0]),
    .shadow_o (shadow_q)
  );

  plc_work_bank u_work (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_i      (xfer_i),
    .shadow_i    (shadow_q),
    .wr_en_i     (wr_en_i),
    .direct_bit_i(wr_data_i[DIRECT_BIT]),
    .work_o      (work_q),
    .direct_o    (direct_q)
  );

  assign passive_lvl = map_levels(work_q, direct_q);
  assign rd_data_o   = pack_read(work_q, direct_q);

  plc_line_driver u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .passive_i(passive_lvl),
    .active_i (active_i),
    .line_o   (line_o)
  );
endmodule

// File: rtl/passive_level_ctrl_chk.sv
module passive_level_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       xfer_i,
  input logic [6:0] active_i,
  input logic [6:0] line_o,
  input logic [5:0] shadow_q
);
  // R1: outputs are zero while in reset
  always_comb begin
    if (!rst_n) begin
      p_reset_zero_r1: assert (rd_data_o == 8'h00 && line_o == 7'h00);
    end
  end

  // R6: reserved bit never reads as one
  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[6] == 1'b0);

  // R3: working low bits hold without a transfer
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_i |=> $stable(rd_data_o[5:0]));

  // R4, R7: transfer loads the shadow value present before the edge
  p_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_i |=> rd_data_o[5:0] == $past(shadow_q));

  // R5: unbuffered bit follows the write on the same edge
  p_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> rd_data_o[7] == $past(wr_data_i[7]));

  // R2, R8: lines follow mapped levels XOR active one edge later
  p_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> line_o == $past({rd_data_o[7], rd_data_o[5:0]} ^ active_i));
endmodule

bind passive_level_ctrl passive_level_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o),
  .xfer_i   (xfer_i),
  .active_i (active_i),
  .line_o   (line_o),
  .shadow_q (shadow_q)
);

// File: tb/test_passive_level_ctrl.sv
module test_passive_level_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       xfer_i = 1'b0;
  logic [6:0] active_i = 7'h00;
  logic [6:0] line_o;

  passive_level_ctrl i_passive_level_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .xfer_i(xfer_i), .active_i(active_i), .line_o(line_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0] rd;
    logic [6:0] line;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  // Bench model of the register state.
  logic [5:0] m_sh = '0;
  logic [5:0] m_wk = '0;
  logic       m_d7 = 1'b0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue what is due after the next edge.
  task automatic step(input logic we, input logic [7:0] d, input logic xf,
                      input logic [6:0] act, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en_i = we; wr_data_i = d; xfer_i = xf; active_i = act;
    e.line = {m_d7, m_wk} ^ act;
    if (xf) m_wk = m_sh;
    if (we) begin m_sh = d[5:0]; m_d7 = d[7]; end
    e.rd  = {m_d7, 1'b0, m_wk};
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare shortly after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " rd"},   {8'h00, rd_data_o}, {8'h00, e.rd});
        check({e.tag, " line"}, {9'h000, line_o},   {9'h000, e.line});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    check("R1 reset rd", {8'h00, rd_data_o}, 16'h0000);
    check("R1 reset line", {9'h000, line_o}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    step(0, 8'h00, 0, 7'h00, "R1 idle");
    step(0, 8'h00, 0, 7'h7F, "R2 all active");
    step(0, 8'h00, 0, 7'h55, "R2 pattern");
    step(1, 8'h2A, 0, 7'h00, "R3 write no xfer");
    step(0, 8'h00, 0, 7'h00, "R3 hold");
    step(0, 8'h00, 1, 7'h00, "R4 transfer");
    step(0, 8'h00, 0, 7'h00, "R4 lines after xfer");
    step(0, 8'h00, 0, 7'h3F, "R2 active inverts");
    step(1, 8'h80, 0, 7'h00, "R5 direct bit set");
    step(0, 8'h00, 0, 7'h40, "R5 line6 active");
    step(0, 8'h00, 0, 7'h00, "R8 line map");
    step(1, 8'h40, 0, 7'h00, "R6 reserved write");
    step(0, 8'h00, 1, 7'h00, "R6 xfer after rsvd");
    step(0, 8'h00, 0, 7'h00, "R6 lines");
    step(1, 8'h15, 0, 7'h00, "R7 preload");
    step(1, 8'hBF, 1, 7'h00, "R7 write with xfer");
    step(0, 8'h00, 0, 7'h00, "R7 old shadow used");
    step(0, 8'h00, 1, 7'h00, "R7 new shadow moves");
    step(0, 8'h00, 0, 7'h12, "R8 mixed active");
    for (int i = 0; i < 6; i++) begin
      step(1, 8'(1 << i), 1, 7'h00, "R8 walk");
      step(0, 8'h00, 1, 7'h00, "R8 walk xfer");
    end
    step(0, 8'h00, 0, 7'h00, "R8 flush");
    step(0, 8'h00, 0, 7'h00, "R2 final");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule